// File: doc/BRIEF.md
# Interrupt Request and Vector Controller

This block collects interrupt requests for a small 8-bit processor core and gives the core one registered pending flag and a 16-bit vector address. There are three sources. The first is an active-low external pin. It passes through a two-stage synchronizer and can be configured for falling-edge or low-level triggering. In level mode several open-drain devices can share the pin as a wired-AND. The second is a vertical-sync source that has an enable bit and a sticky flag. The third is a display-data serial channel whose request is gated by its own enable bit.

Software programs three byte-wide registers over a simple write/read bus. The core supplies its global interrupt mask. When the core fetches a vector it raises an acknowledge. While the acknowledge is high the vector output and the pending flag hold still, and an edge-mode request is retired when its vector is the one being fetched.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, irqPending and vectorAddr are 0. Every register reads back 0, which means level mode and all enables off.
- R2: The register fields read back as written. Address 0x08 bit 3 is the trigger select (1 = edge, 0 = level). Address 0x0C bit 7 is the sync enable and bit 0 is the sync flag. Address 0x18 bit 6 is the serial enable. All other bits read 0.
- R3: In level mode the external request follows the synchronized pin: it is active while that pin is low. The pin is sampled by two flops. irqPending is the registered result one edge after that, so a pin that is still low after service raises the request again.
- R4: In edge mode a falling edge on the synchronized pin latches a request, and one low cycle is enough to capture it. The latch stays set after the pin returns high.
- R5: The edge latch clears on a cycle where irqAck is high, irqPending is high and vectorAddr is the external vector. A falling edge detected in that same cycle keeps the latch set.
- R6: A high pulse on syncEdge sets the sync flag. The flag clears only when 0x0C is written with bit 0 = 0, and writing bit 0 = 1 leaves it unchanged. A new pulse in the same cycle as a clearing write wins. The flag raises a request only while the sync enable is 1.
- R7: serialReq raises a request only while the serial enable is 1.
- R8: While iMask is 1, irqPending is 0 on the next edge that has no irqAck.
- R9: The priority order is external, then sync, then serial. The vectors are 0x3FFA, 0x3FF8 and 0x3FF6, and vectorAddr is registered on the edge after the requests are seen.
- R10: While irqAck is high, irqPending and vectorAddr keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register address |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdData | output | 8 | Combinational read data for busAddr |
| pinN | input | 1 | External interrupt pin, active low |
| syncEdge | input | 1 | One-cycle pulse from the sync edge detector |
| serialReq | input | 1 | Level request from the serial channel |
| iMask | input | 1 | Global interrupt mask from the core |
| irqAck | input | 1 | Core vector-fetch acknowledge |
| irqPending | output | 1 | Registered request to the core |
| vectorAddr | output | 16 | Registered vector address |

## Verification
The assertions assume the following about the inputs: irqAck is raised only while irqPending is high, bus writes arrive only as single-cycle strobes, and syncEdge is synchronous to clk. The bench drives every input one time unit after the falling clock edge and asserts the acknowledge only in cycles where the pending output it has sampled is high. It keeps the randomized phase inside these limits as well, including during held multi-cycle acknowledges.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_EXT  = 2'd1,
    SRC_SYNC = 2'd2,
    SRC_SER  = 2'd3
  } src_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrMode;
    logic wrSync;
    logic wrSer;
    logic clrEdge;
    logic load;
    logic pend;
    src_e sel;
  } strobe_t;

  localparam int NUM_SRC = 3;

endpackage

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              VEC_W     = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] SYNC_ADDR = 8'h0C,
  parameter logic [ADDR_W-1:0] SER_ADDR  = 8'h18,
  parameter logic [VEC_W-1:0]  EXT_VEC   = 16'h3FFA
) (
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWrEn,
  input  logic               irqAck,
  input  logic               iMask,
  input  logic [NUM_SRC-1:0] reqVec,     // [2]=ext, [1]=sync, [0]=serial
  input  logic               irqPending,
  input  logic [VEC_W-1:0]   vectorAddr,
  output strobe_t            stb
);

  localparam src_e [NUM_SRC-1:0] SRC_OF = {SRC_EXT, SRC_SYNC, SRC_SER};

  src_e winner;

  // highest index wins: scan from low to high so the last hit stays
  always_comb begin
    winner = SRC_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (reqVec[i]) winner = SRC_OF[i];
    end
  end

  always_comb begin
    stb.wrMode  = busWrEn && (busAddr == MODE_ADDR);
    stb.wrSync  = busWrEn && (busAddr == SYNC_ADDR);
    stb.wrSer   = busWrEn && (busAddr == SER_ADDR);
    stb.clrEdge = irqAck && irqPending && (vectorAddr == EXT_VEC);
    stb.load    = !irqAck;
    stb.pend    = !iMask && (|reqVec);
    stb.sel     = winner;
  end

endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int              ADDR_W        = 8,
  parameter int              DATA_W        = 8,
  parameter int              VEC_W         = 16,
  parameter int              SYNC_STAGES   = 2,
  parameter int              MODE_BIT      = 3,
  parameter int              SYNC_EN_BIT   = 7,
  parameter int              SYNC_FLAG_BIT = 0,
  parameter int              SER_EN_BIT    = 6,
  parameter logic [ADDR_W-1:0] MODE_ADDR   = 8'h08,
  parameter logic [ADDR_W-1:0] SYNC_ADDR   = 8'h0C,
  parameter logic [ADDR_W-1:0] SER_ADDR    = 8'h18,
  parameter logic [VEC_W-1:0]  EXT_VEC     = 16'h3FFA,
  parameter logic [VEC_W-1:0]  SYNC_VEC    = 16'h3FF8,
  parameter logic [VEC_W-1:0]  SER_VEC     = 16'h3FF6
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWrData,
  output logic [DATA_W-1:0]  busRdData,
  input  logic               pinN,
  input  logic               syncEdge,
  input  logic               serialReq,
  output logic [NUM_SRC-1:0] reqVec,
  output logic               syncFlag,
  output logic               irqPending,
  output logic [VEC_W-1:0]   vectorAddr
);

  // pinPipe[0..SYNC_STAGES-1] synchronizer, pinPipe[SYNC_STAGES] previous value
  logic [SYNC_STAGES:0] pinPipe;
  logic pinS, pinPrev, fallDet;
  logic modeEdge, syncEn, serEn, edgeLatch;
  logic [VEC_W-1:0] vecNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPipe <= '1;
    else       pinPipe <= {pinPipe[SYNC_STAGES-1:0], pinN};
  end

  assign pinS    = pinPipe[SYNC_STAGES-1];
  assign pinPrev = pinPipe[SYNC_STAGES];
  assign fallDet = pinPrev && !pinS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEdge <= 1'b0;
      syncEn   <= 1'b0;
      serEn    <= 1'b0;
    end else begin
      if (stb.wrMode) modeEdge <= busWrData[MODE_BIT];
      if (stb.wrSync) syncEn   <= busWrData[SYNC_EN_BIT];
      if (stb.wrSer)  serEn    <= busWrData[SER_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        syncFlag <= 1'b0;
    else if (syncEdge)                                syncFlag <= 1'b1;
    else if (stb.wrSync && !busWrData[SYNC_FLAG_BIT]) syncFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            edgeLatch <= 1'b0;
    else if (!modeEdge)   edgeLatch <= 1'b0;
    else if (fallDet)     edgeLatch <= 1'b1;
    else if (stb.clrEdge) edgeLatch <= 1'b0;
  end

  assign reqVec = {(modeEdge ? edgeLatch : !pinS), syncEn && syncFlag, serEn && serialReq};

  always_comb begin
    case (stb.sel)
      SRC_EXT:  vecNext = EXT_VEC;
      SRC_SYNC: vecNext = SYNC_VEC;
      SRC_SER:  vecNext = SER_VEC;
      default:  vecNext = vectorAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqPending <= 1'b0;
      vectorAddr <= '0;
    end else if (stb.load) begin
      irqPending <= stb.pend;
      vectorAddr <= vecNext;
    end
  end

  always_comb begin
    busRdData = '0;
    case (busAddr)
      MODE_ADDR: busRdData[MODE_BIT] = modeEdge;
      SYNC_ADDR: begin
        busRdData[SYNC_EN_BIT]   = syncEn;
        busRdData[SYNC_FLAG_BIT] = syncFlag;
      end
      SER_ADDR:  busRdData[SER_EN_BIT] = serEn;
      default:   busRdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter int              VEC_W     = 16,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 8'h08,
  parameter logic [ADDR_W-1:0] SYNC_ADDR = 8'h0C,
  parameter logic [ADDR_W-1:0] SER_ADDR  = 8'h18,
  parameter logic [VEC_W-1:0]  EXT_VEC   = 16'h3FFA,
  parameter logic [VEC_W-1:0]  SYNC_VEC  = 16'h3FF8,
  parameter logic [VEC_W-1:0]  SER_VEC   = 16'h3FF6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              pinN,
  input  logic              syncEdge,
  input  logic              serialReq,
  input  logic              iMask,
  input  logic              irqAck,
  output logic              irqPending,
  output logic [VEC_W-1:0]  vectorAddr
);

  strobe_t            stb;
  logic [NUM_SRC-1:0] reqVec;
  logic               syncFlag;

  irqv_ctrl #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .MODE_ADDR(MODE_ADDR),
    .SYNC_ADDR(SYNC_ADDR), .SER_ADDR(SER_ADDR), .EXT_VEC(EXT_VEC)
  ) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .irqAck(irqAck), .iMask(iMask),
    .reqVec(reqVec), .irqPending(irqPending), .vectorAddr(vectorAddr), .stb(stb)
  );

  irqv_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
    .MODE_ADDR(MODE_ADDR), .SYNC_ADDR(SYNC_ADDR), .SER_ADDR(SER_ADDR),
    .EXT_VEC(EXT_VEC), .SYNC_VEC(SYNC_VEC), .SER_VEC(SER_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .pinN(pinN), .syncEdge(syncEdge), .serialReq(serialReq),
    .reqVec(reqVec), .syncFlag(syncFlag), .irqPending(irqPending), .vectorAddr(vectorAddr)
  );

endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter int              VEC_W     = 16,
  parameter logic [ADDR_W-1:0] SYNC_ADDR = 8'h0C,
  parameter logic [VEC_W-1:0]  EXT_VEC   = 16'h3FFA,
  parameter logic [VEC_W-1:0]  SYNC_VEC  = 16'h3FF8,
  parameter logic [VEC_W-1:0]  SER_VEC   = 16'h3FF6
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busWrEn,
  input logic              iMask,
  input logic              irqAck,
  input logic              irqPending,
  input logic [VEC_W-1:0]  vectorAddr,
  input logic              syncFlag
);

  a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (iMask && !irqAck) |=> !irqPending);

  a_r10_hold_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    irqAck |=> ($stable(vectorAddr) && $stable(irqPending)));

  a_r9_legal_vector: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |-> (vectorAddr == EXT_VEC || vectorAddr == SYNC_VEC || vectorAddr == SER_VEC));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (syncFlag && !(busWrEn && busAddr == SYNC_ADDR && !busWrData[0])) |=> syncFlag);

endmodule

bind irq_vector_ctrl irqv_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W), .SYNC_ADDR(SYNC_ADDR),
  .EXT_VEC(EXT_VEC), .SYNC_VEC(SYNC_VEC), .SER_VEC(SER_VEC)
) u_chk (.*);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

  logic clk = 0;
  logic rstN = 0;
  logic [7:0] busAddr = 0, busWrData = 0;
  logic busWrEn = 0;
  logic [7:0] busRdData;
  logic pinN = 1, syncEdge = 0, serialReq = 0, iMask = 0, irqAck = 0;
  logic irqPending;
  logic [15:0] vectorAddr;

  always #5 clk = ~clk;

  irq_vector_ctrl u_dut (.*);

  int total = 0, failed = 0;
  bit done = 0;
  string tag = "R1";

  // reference model state
  bit mS1 = 1, mS2 = 1, mPrev = 1;
  bit mMode, mSyncEn, mFlag, mSerEn, mLatch, mPend;
  int mVec;

  task automatic chk(string t, int act, int exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s act=%h exp=%h at %0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 1; mS2 = 1; mPrev = 1;
      mMode = 0; mSyncEn = 0; mFlag = 0; mSerEn = 0; mLatch = 0; mPend = 0; mVec = 0;
    end else begin
      bit ext, sy, se, fall, clr;
      fall = mPrev && !mS2;
      ext = mMode ? mLatch : !mS2;
      sy = mSyncEn && mFlag;
      se = mSerEn && serialReq;
      clr = irqAck && mPend && (mVec == 'h3FFA);
      if (!mMode) mLatch = 0;
      else if (fall) mLatch = 1;
      else if (clr) mLatch = 0;
      if (!irqAck) begin
        mPend = !iMask && (ext || sy || se);
        if (ext) mVec = 'h3FFA;
        else if (sy) mVec = 'h3FF8;
        else if (se) mVec = 'h3FF6;
      end
      if (syncEdge) mFlag = 1;
      else if (busWrEn && busAddr == 8'h0C && !busWrData[0]) mFlag = 0;
      if (busWrEn && busAddr == 8'h08) mMode = busWrData[3];
      if (busWrEn && busAddr == 8'h0C) mSyncEn = busWrData[7];
      if (busWrEn && busAddr == 8'h18) mSerEn = busWrData[6];
      mPrev = mS2; mS2 = mS1; mS1 = pinN;
    end
  end

  function automatic int modelRd(logic [7:0] a);
    case (a)
      8'h08: return mMode ? 8'h08 : 0;
      8'h0C: return (mSyncEn ? 8'h80 : 0) | (mFlag ? 1 : 0);
      8'h18: return mSerEn ? 8'h40 : 0;
      default: return 0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      chk({tag, " pending"}, irqPending, mPend);
      chk({tag, " vector"}, vectorAddr, mVec);
      chk({tag, " readback"}, busRdData, modelRd(busAddr));
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1;
    cyc();
    busWrEn = 0;
  endtask

  task automatic rd(string t, logic [7:0] a, int exp);
    busAddr = a;
    #1;
    chk({t, " direct read"}, busRdData, exp);
  endtask

  task automatic ackOnce();
    irqAck = 1; cyc(); irqAck = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog act=running exp=done");
      done = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    cyc(3);
    chk("R1 reset pending", irqPending, 0);
    chk("R1 reset vector", vectorAddr, 0);
    rd("R1", 8'h08, 0); rd("R1", 8'h0C, 0); rd("R1", 8'h18, 0);
    rstN = 1; cyc(2);

    tag = "R2";
    wr(8'h08, 8'hFF); rd("R2", 8'h08, 8'h08);
    wr(8'h18, 8'hFF); rd("R2", 8'h18, 8'h40);
    wr(8'h0C, 8'h81); rd("R2", 8'h0C, 8'h80);
    rd("R2", 8'h20, 0);
    wr(8'h08, 0); wr(8'h18, 0); wr(8'h0C, 0);

    tag = "R3";
    pinN = 0; cyc(2);
    chk("R3 not yet pending", irqPending, 0);
    cyc(1);
    chk("R3 level pending", irqPending, 1);
    chk("R3 level vector", vectorAddr, 'h3FFA);
    ackOnce(); cyc(2);
    chk("R3 still low re-requests", irqPending, 1);
    pinN = 1; cyc(4);
    chk("R3 released", irqPending, 0);

    tag = "R4";
    wr(8'h08, 8'h08);
    pinN = 0; cyc(1); pinN = 1; cyc(5);
    chk("R4 pulse latched", irqPending, 1);

    tag = "R5";
    ackOnce(); cyc(2);
    chk("R5 ack clears latch", irqPending, 0);
    pinN = 0; cyc(2); pinN = 1; cyc(3);
    chk("R5 second edge", irqPending, 1);
    pinN = 0; cyc(1);
    irqAck = 1; cyc(1); irqAck = 0; pinN = 1; cyc(3);
    chk("R5 edge during ack kept", irqPending, 1);
    ackOnce(); cyc(2);
    wr(8'h08, 0);

    tag = "R6";
    syncEdge = 1; cyc(); syncEdge = 0;
    rd("R6", 8'h0C, 8'h01);
    cyc(2);
    chk("R6 disabled flag idle", irqPending, 0);
    wr(8'h0C, 8'h81); cyc(2);
    chk("R6 enabled flag", irqPending, 1);
    chk("R6 vector", vectorAddr, 'h3FF8);
    rd("R6", 8'h0C, 8'h81);
    busAddr = 8'h0C; busWrData = 8'h80; busWrEn = 1; syncEdge = 1; cyc();
    busWrEn = 0; syncEdge = 0;
    rd("R6 set wins", 8'h0C, 8'h81);
    wr(8'h0C, 8'h80);
    rd("R6 cleared", 8'h0C, 8'h80);
    cyc(2);
    chk("R6 no request", irqPending, 0);

    tag = "R7";
    serialReq = 1; cyc(3);
    chk("R7 disabled", irqPending, 0);
    wr(8'h18, 8'h40); cyc(2);
    chk("R7 enabled", irqPending, 1);
    chk("R7 vector", vectorAddr, 'h3FF6);

    tag = "R8";
    iMask = 1; cyc(2);
    chk("R8 masked", irqPending, 0);
    iMask = 0; cyc(2);

    tag = "R9";
    syncEdge = 1; cyc(); syncEdge = 0; cyc(2);
    chk("R9 sync over serial", vectorAddr, 'h3FF8);
    pinN = 0; cyc(4);
    chk("R9 ext over all", vectorAddr, 'h3FFA);
    pinN = 1; cyc(4);
    chk("R9 back to sync", vectorAddr, 'h3FF8);

    tag = "R10";
    irqAck = 1; pinN = 0; cyc(6);
    chk("R10 vector held", vectorAddr, 'h3FF8);
    irqAck = 0; cyc(2);
    chk("R10 after release", vectorAddr, 'h3FFA);
    pinN = 1; cyc(4);

    tag = "R9";
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom;
      pinN = (r[3:0] != 0) ? pinN : ~pinN;
      syncEdge = (r[7:4] == 0);
      serialReq = r[8] ^ r[9] ? serialReq : r[10];
      iMask = (r[14:11] == 0);
      irqAck = irqPending && r[15] && r[16];
      busWrEn = (r[20:17] == 0);
      case (r[22:21])
        0: busAddr = 8'h08;
        1: busAddr = 8'h0C;
        2: busAddr = 8'h18;
        default: busAddr = 8'h33;
      endcase
      busWrData = r[31:24];
      cyc();
      if (irqAck && r[23]) begin
        busWrEn = 0; syncEdge = 0; cyc(2);
      end
    end
    busWrEn = 0; irqAck = 0; syncEdge = 0;
    cyc(2);
    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule